// File: doc/BRIEF.md
# Out-of-Band Gap Pattern Detector

This block sits behind a serial receiver's squelch comparator and recognises the two out-of-band signalling patterns used at link bring-up: the initialisation/reset pattern and the wake pattern. Both are trains of short bursts separated by quiet periods. The only difference between them is how long each quiet period lasts. The block times every quiet gap between bursts with a free-running clock and sorts each gap into one of the two windows or rejects it. It counts how many gaps of the same class arrive back to back and pulses one detection output when the run is long enough.

The nanosecond window limits and the clock period are parameters. Cycle limits are derived from them at elaboration. The squelch input is synchronised on entry. Very short bursts are treated as noise, and a long silence abandons any partial run. A link controller uses the two pulses as events in its bring-up sequence.

Top module: `oob_gap_classifier`

## Requirements
- R1: Gap length is the number of clock cycles between the last high sample of a qualified burst and the first high sample of the next burst. A gap is a wake gap when its length times the clock period lies within 103.47 ns to 109.87 ns. The lower limit is rounded up to whole cycles and the upper limit rounded down, which gives exactly 13 cycles at 8 ns.
- R2: A gap is an init gap when its length times the clock period lies within 310.4 ns to 329.6 ns, rounded the same way. This gives 39 to 41 cycles at 8 ns. Gaps of 38 and 42 cycles are not init gaps.
- R3: After RUN_LEN (default 4) consecutive gaps of one class, the block pulses that class's output (`det_init` or `det_wake`) once and starts a new run. Eight consecutive wake gaps therefore give two wake pulses.
- R4: A gap that falls in neither window clears the run, so a later detection needs RUN_LEN fresh gaps.
- R5: A gap of the other class discards the current run and starts a new run that counts that gap as its first.
- R6: Once the input has been quiet for QUIET_PS (default 600 ns, which is 75 cycles) after a qualified burst, the run is cleared. The next burst then starts fresh, with no gap measured before it.
- R7: A burst shorter than GLITCH_CYC (default 3) cycles is ignored. It neither ends nor starts a gap, and its cycles count as part of the surrounding gap.
- R8: Each detection output is high for one cycle at a time, and the two outputs are never high together.
- R9: Synchronous reset clears all counters and the synchroniser, and holds both outputs low. The first burst after reset has no gap before it.
- R10: `sig_det` passes through two flip-flops before any timing logic. A detection pulse becomes visible GLITCH_CYC+2 clock edges after the first edge that samples the high level of the burst that closes the run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock, period CLK_PS |
| rst | input | 1 | Synchronous active-high reset |
| sig_det | input | 1 | Asynchronous squelch output, high during a burst |
| det_init | output | 1 | One-cycle pulse when an init/reset pattern is recognised |
| det_wake | output | 1 | One-cycle pulse when a wake pattern is recognised |

## Verification
The bench goes after the cycle counts on both sides of each window: 12, 13 and 14 cycles for wake, and 38 through 42 for init. A rounding mistake in either direction would accept a neighbour or drop the single legal wake length. Mixed runs broken by bad gaps, class changes and long silences check that the run counter restarts. A design that kept a stale count would fire early. Gaps split by two-cycle glitches must still count as one gap. A glitch filter that was missing would split them into short rejected gaps, and the pattern would never fire. Resetting in the middle of a run and measuring the exact pulse latency catch counters that survive reset and a synchroniser with the wrong number of stages.

// File: rtl/oob_gap_classifier.sv
`timescale 1ns/1ps
module oob_gap_classifier #(
  parameter int CLK_PS      = 8000,
  parameter int WAKE_MIN_PS = 103470,
  parameter int WAKE_MAX_PS = 109870,
  parameter int INIT_MIN_PS = 310400,
  parameter int INIT_MAX_PS = 329600,
  parameter int QUIET_PS    = 600000,
  parameter int GLITCH_CYC  = 3,
  parameter int RUN_LEN     = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_det,
  output logic det_init,
  output logic det_wake
);
  localparam int WAKE_LO   = (WAKE_MIN_PS + CLK_PS - 1) / CLK_PS;
  localparam int WAKE_HI   = WAKE_MAX_PS / CLK_PS;
  localparam int INIT_LO   = (INIT_MIN_PS + CLK_PS - 1) / CLK_PS;
  localparam int INIT_HI   = INIT_MAX_PS / CLK_PS;
  localparam int QUIET_CYC = QUIET_PS / CLK_PS;
  localparam int GW = $clog2(QUIET_CYC + 1);
  localparam int BW = $clog2(GLITCH_CYC + 1);
  localparam int RW = $clog2(RUN_LEN + 1);

  logic [1:0]    sync;
  logic          s_q, qburst, gap_live, run_is_init;
  logic [BW-1:0] burst_cnt;
  logic [GW-1:0] gap_cnt, gap_hold, gap_now;
  logic [RW-1:0] run_cnt, run_next;

  wire s       = sync[1];
  wire rise    = s & ~s_q;
  wire qual    = s & (burst_cnt == BW'(GLITCH_CYC - 1));
  wire b_end   = ~s & qburst;
  wire timeout = gap_live & ~s & (gap_cnt >= GW'(QUIET_CYC));
  wire hit     = qual & gap_live;

  assign gap_now = rise ? gap_cnt : gap_hold;
  wire in_wake = (gap_now >= GW'(WAKE_LO)) && (gap_now <= GW'(WAKE_HI));
  wire in_init = (gap_now >= GW'(INIT_LO)) && (gap_now <= GW'(INIT_HI));
  wire same    = (run_cnt == '0) || (run_is_init == in_init);

  always_comb begin
    if (!(in_wake || in_init)) run_next = '0;
    else if (same)             run_next = run_cnt + RW'(1);
    else                       run_next = RW'(1);
  end

  wire done = hit && (in_wake || in_init) && (run_next == RW'(RUN_LEN));

  always_ff @(posedge clk) begin
    if (rst) begin
      sync        <= '0;
      s_q         <= 1'b0;
      burst_cnt   <= '0;
      qburst      <= 1'b0;
      gap_live    <= 1'b0;
      gap_cnt     <= '0;
      gap_hold    <= '0;
      run_cnt     <= '0;
      run_is_init <= 1'b0;
      det_init    <= 1'b0;
      det_wake    <= 1'b0;
    end else begin
      sync <= {sync[0], sig_det};
      s_q  <= s;
      if (!s) burst_cnt <= '0;
      else if (burst_cnt != BW'(GLITCH_CYC)) burst_cnt <= burst_cnt + BW'(1);
      if (rise) gap_hold <= gap_cnt;

      det_init <= done && in_init;
      det_wake <= done && in_wake;

      if (qual) qburst <= 1'b1;
      else if (b_end) qburst <= 1'b0;

      if (b_end) begin
        gap_live <= 1'b1;
        gap_cnt  <= GW'(1);
      end else if (qual) begin
        gap_live <= 1'b0;
      end else if (timeout) begin
        gap_live <= 1'b0;
      end else if (gap_live && gap_cnt < GW'(QUIET_CYC)) begin
        gap_cnt <= gap_cnt + GW'(1);
      end

      if (hit) begin
        run_cnt     <= done ? '0 : run_next;
        run_is_init <= in_init;
      end else if (timeout) begin
        run_cnt <= '0;
      end
    end
  end

  AST_NOT_BOTH:   assert property (@(posedge clk) disable iff (rst) !(det_init && det_wake)); // R8
  AST_INIT_PULSE: assert property (@(posedge clk) disable iff (rst) det_init |=> !det_init); // R8
  AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (rst) det_wake |=> !det_wake); // R8
  AST_RUN_BOUND:  assert property (@(posedge clk) disable iff (rst) run_cnt < RW'(RUN_LEN)); // R3
  AST_GAP_BOUND:  assert property (@(posedge clk) disable iff (rst) gap_cnt <= GW'(QUIET_CYC)); // R6
  AST_DET_IN_BURST: assert property (@(posedge clk) disable iff (rst) (det_init || det_wake) |-> $past(s)); // R7
  AST_RESET_CLEAR: assert property (@(posedge clk) $past(rst) |-> (run_cnt == '0) && !gap_live && !det_init && !det_wake); // R9
endmodule

// File: tb/oob_gap_classifier_test.sv
`timescale 1ns/1ps
module oob_gap_classifier_test;
  logic clk = 1'b0, rst = 1'b1, sig = 1'b0;
  logic det_init, det_wake;
  int total = 0, bad = 0;
  int n_init = 0, n_wake = 0, width_err = 0;
  logic p_init = 1'b0, p_wake = 1'b0;
  int gq[16];
  int gn;

  always #4 clk = ~clk;

  oob_gap_classifier uut (.clk(clk), .rst(rst), .sig_det(sig), .det_init(det_init), .det_wake(det_wake));

  always @(negedge clk) begin
    if (!rst) begin
      if (det_init) n_init++;
      if (det_wake) n_wake++;
      if ((det_init && p_init) || (det_wake && p_wake) || (det_init && det_wake)) width_err++;
    end
    p_init <= det_init;
    p_wake <= det_wake;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cls(input int g);
    real ns = g * 8.0;
    if (ns >= 103.47 && ns <= 109.87) return 2;
    if (ns >= 310.4 && ns <= 329.6) return 1;
    return 0;
  endfunction

  task automatic model(output int ei, output int ew);
    int run = 0, c0 = 0;
    ei = 0; ew = 0;
    for (int i = 0; i < gn; i++) begin
      int c = cls(gq[i]);
      if (c == 0) run = 0;
      else if (run > 0 && c != c0) begin run = 1; c0 = c; end
      else begin run++; c0 = c; end
      if (run == 4) begin
        if (c == 1) ei++; else ew++;
        run = 0;
      end
    end
  endtask

  task automatic drive(input logic lvl, input int cyc);
    sig = lvl;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic run_seq(input string req, input int blen);
    int i0, w0, ei, ew;
    drive(0, 90);
    i0 = n_init; w0 = n_wake;
    drive(1, blen);
    for (int i = 0; i < gn; i++) begin
      drive(0, gq[i]);
      drive(1, blen);
    end
    drive(0, 90);
    model(ei, ew);
    check({req, " init count"}, n_init - i0, ei);
    check({req, " wake count"}, n_wake - w0, ew);
  endtask

  task automatic set4(input int g);
    gn = 4;
    for (int i = 0; i < 4; i++) gq[i] = g;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lat, i0, w0;
    int pool[14] = '{12, 13, 14, 38, 39, 40, 41, 42, 13, 13, 40, 40, 60, 80};
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    check("R9 reset init low", int'(det_init), 0);
    check("R9 reset wake low", int'(det_wake), 0);
    rst = 1'b0;

    set4(13); run_seq("R1 wake 13", 4);
    set4(12); run_seq("R1 wake 12 rejected", 4);
    set4(14); run_seq("R1 wake 14 rejected", 4);
    set4(39); run_seq("R2 init 39", 3);
    set4(41); run_seq("R2 init 41", 5);
    set4(38); run_seq("R2 init 38 rejected", 4);
    set4(42); run_seq("R2 init 42 rejected", 4);
    gn = 8; for (int i = 0; i < 8; i++) gq[i] = 13;
    run_seq("R3 eight wake gaps", 4);
    gn = 7; gq = '{13, 13, 13, 50, 13, 13, 13, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    run_seq("R4 bad gap clears", 4);
    gn = 7; gq = '{40, 40, 40, 13, 13, 13, 13, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    run_seq("R5 class change", 4);
    gn = 8; gq = '{39, 39, 39, 90, 39, 39, 39, 39, 0, 0, 0, 0, 0, 0, 0, 0};
    run_seq("R6 long quiet", 4);

    // R7: glitches inside 13-cycle gaps are absorbed
    drive(0, 90);
    w0 = n_wake;
    drive(1, 4);
    for (int i = 0; i < 4; i++) begin
      drive(0, 5); drive(1, 2); drive(0, 6); drive(1, 4);
    end
    drive(0, 90);
    check("R7 glitch inside gap", n_wake - w0, 1);
    // R7: bursts of two cycles only, never qualified
    w0 = n_wake;
    for (int i = 0; i < 6; i++) begin drive(1, 2); drive(0, 13); end
    drive(0, 90);
    check("R7 short bursts ignored", n_wake - w0, 0);

    // R9: reset in mid run
    w0 = n_wake;
    drive(1, 4);
    for (int i = 0; i < 3; i++) begin drive(0, 13); drive(1, 4); end
    drive(0, 5);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    drive(0, 8); drive(1, 4); drive(0, 13); drive(1, 4); drive(0, 90);
    check("R9 reset clears run", n_wake - w0, 0);

    // R10: latency from closing burst
    drive(1, 4);
    for (int i = 0; i < 3; i++) begin drive(0, 13); drive(1, 4); end
    drive(0, 13);
    sig = 1'b1; lat = 0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (det_wake && lat == 0) lat = k;
    end
    drive(0, 90);
    check("R10 pulse latency", lat, 5);

    for (int r = 0; r < 40; r++) begin
      gn = 4 + int'($urandom_range(0, 8));
      for (int i = 0; i < gn; i++) gq[i] = pool[$urandom_range(0, 13)];
      run_seq("R3 random run", 3 + int'($urandom_range(0, 3)));
    end

    check("R8 pulse width and exclusivity", width_err, 0);
    i0 = n_init;
    check("R3 some init detections seen", int'(i0 > 0), 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule